// File: doc/BRIEF.md
# DMA Request Queue Engine

The engine walks a circular ring of 64-bit transfer descriptors that the host fills. It takes one descriptor at a time, from the ring head. It decodes the transfer kind and starts a to-device or from-device move on a valid/ready mover handshake. A move may be held back until every earlier move in a chosen direction has drained. When the descriptor asks for it, the engine then issues a doorbell write of the encoded width. Last, it writes a completion entry with a status code into a response ring that the host drains.

An interrupt pulse marks each moment when the response ring goes from holding nothing to holding an entry. A force input produces a pulse on demand. Moves without a doorbell are left outstanding once the mover accepts them. One counter per direction tracks them, and those counters drive both the fences and the wait before a doorbell.

Descriptor layout: [1:0] kind, [3:2] doorbell width, [4] doorbell enable, [28:5] doorbell address, [29] from-device fence, [30] to-device fence, [31] spare, [63:32] doorbell data. A response entry carries the status in [7:0] and the request slot index, zero-extended, in [15:8].

Top module: `dmaq_engine`

## Requirements
- R1: Kind code 1 starts a move with `mv_dir`=0 (to device). Code 2 starts one with `mv_dir`=1 (from device). Code 0 starts no move. Each of these completes with status 0.
- R2: Kind code 3 starts no move and no doorbell, and completes with status 1.
- R3: When bit 4 is set, the engine issues one doorbell write with `db_size` equal to bits [3:2] (0 = 32-bit, 1 = 16-bit, 2 = 8-bit) and `db_data` equal to bits [63:32]. When bit 4 is clear, no doorbell is written, whatever the width field holds.
- R4: With bit 4 set and width code 3, no doorbell is written and the entry carries status 2. A move the descriptor asks for is still performed.
- R5: With bit 30 set, the move does not start while any to-device move is still outstanding.
- R6: With bit 29 set, the move does not start while any from-device move is still outstanding. Outstanding moves in the other direction do not hold it.
- R7: Descriptors start and complete strictly in ring order, so a held descriptor also holds every descriptor behind it.
- R8: A doorbell is issued only after every outstanding move in the request's direction, its own included, has reported done on `td_done` or `fd_done`.
- R9: Each response entry holds the status in [7:0] and the request's slot index in [15:8]. It is written only after the doorbell handshake, when there is one, has completed.
- R10: The response ring counts as full when tail+1 equals the host head. While it is full the engine stalls, and it overwrites no unconsumed entry.
- R11: `irq` pulses for one cycle after an entry is written into a ring that is empty. Emptiness is judged against the head value in effect that cycle, including a host head write in that same cycle. A write into a non-empty ring gives no pulse.
- R12: A pulse on `irq_force` produces an `irq` pulse in the next cycle.
- R13: While `mv_valid` or `db_valid` is high and its ready input is low, the valid output and its payload hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr_en | input | 1 | Host write strobe into the descriptor ring |
| req_wr_addr | input | REQ_AW | Descriptor slot to write |
| req_wr_data | input | 64 | Descriptor value |
| req_tail | input | REQ_AW | Host-owned tail of the descriptor ring |
| req_head | output | REQ_AW | Engine-owned head of the descriptor ring |
| mv_valid | output | 1 | Move request valid |
| mv_ready | input | 1 | Mover accepts the request |
| mv_dir | output | 1 | 0 to device, 1 from device |
| mv_idx | output | REQ_AW | Descriptor slot of the move |
| td_done | input | 1 | One to-device move finished |
| fd_done | input | 1 | One from-device move finished |
| db_valid | output | 1 | Doorbell write valid |
| db_ready | input | 1 | Doorbell write accepted |
| db_size | output | 2 | Doorbell width code |
| db_addr | output | 24 | Doorbell address |
| db_data | output | 32 | Doorbell data |
| rsp_rd_addr | input | RSP_AW | Response slot to read |
| rsp_rd_data | output | 16 | Response entry, one cycle after the address |
| rsp_head_we | input | 1 | Host head write strobe |
| rsp_head_wdata | input | RSP_AW | New host head of the response ring |
| rsp_head | output | RSP_AW | Current host head of the response ring |
| rsp_tail | output | RSP_AW | Engine-owned tail of the response ring |
| irq_force | input | 1 | Request an interrupt pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
Two events can fall in the same cycle. One is the engine writing a response entry. The other is the host moving the response head. The bench provokes this by timing a host head write so that it lands on the cycle the engine writes the entry. The ring still holds an older entry when the head write arrives. The bench counts an `irq` pulse as correct only if the new head value makes the ring empty at the moment of the write. It also confirms that a write into a ring that stays non-empty gives no pulse, and that a force pulse gives one without any write.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int DESC_W     = 64;
  localparam int STAT_W     = 8;
  localparam int DB_AW      = 24;
  localparam int DB_DW      = 32;
  localparam int F_KIND     = 0;
  localparam int F_DBW      = 2;
  localparam int F_DBEN     = 4;
  localparam int F_DBADDR   = 5;
  localparam int F_FD_FENCE = 29;
  localparam int F_TD_FENCE = 30;
  localparam int F_SPARE    = 31;
  localparam int F_DBDATA   = 32;

  localparam logic [STAT_W-1:0] ST_OK      = 8'd0;
  localparam logic [STAT_W-1:0] ST_BAD_KND = 8'd1;
  localparam logic [STAT_W-1:0] ST_BAD_DB  = 8'd2;

  typedef enum logic [1:0] {
    K_NONE = 2'd0, K_TO_DEV = 2'd1, K_FROM_DEV = 2'd2, K_BAD = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_FENCE, S_ISSUE, S_DRAIN, S_DBCHK, S_DBELL, S_POST
  } st_e;
endpackage

// File: rtl/dmaq_ram.sv
module dmaq_ram #(
  parameter int AW = 3,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dmaq_track.sv
module dmaq_track #(
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_fire,
  input  logic                  start_dir,
  input  logic                  td_done,
  input  logic                  fd_done,
  output logic [1:0][CNT_W-1:0] cnt
);
  logic [1:0] done_v;
  assign done_v = {fd_done, td_done};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic inc;
    assign inc = start_fire && (start_dir == d[0]);
    always_ff @(posedge clk) begin
      if (rst) cnt[d] <= '0;
      else if (inc && !done_v[d]) cnt[d] <= cnt[d] + 1'b1;
      else if (!inc && done_v[d]) cnt[d] <= cnt[d] - 1'b1;
    end
  end
endmodule

// File: rtl/dmaq_resp.sv
module dmaq_resp #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          post,
  input  logic          head_we,
  input  logic [AW-1:0] head_wdata,
  input  logic          irq_force,
  output logic [AW-1:0] tail,
  output logic [AW-1:0] head,
  output logic          full,
  output logic          irq
);
  logic [AW-1:0] head_eff;
  logic [AW-1:0] tail_nx;

  assign head_eff = head_we ? head_wdata : head;
  assign tail_nx  = tail + 1'b1;
  assign full     = (tail_nx == head);

  always_ff @(posedge clk) begin
    if (rst) begin
      tail <= '0;
      head <= '0;
      irq  <= 1'b0;
    end else begin
      if (head_we) head <= head_wdata;
      if (post)    tail <= tail_nx;
      irq <= (post && (tail == head_eff)) || irq_force;
    end
  end
endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
  import dmaq_pkg::*;
#(
  parameter int REQ_AW = 3,
  parameter int RSP_AW = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr_en,
  input  logic [REQ_AW-1:0] req_wr_addr,
  input  logic [63:0]       req_wr_data,
  input  logic [REQ_AW-1:0] req_tail,
  output logic [REQ_AW-1:0] req_head,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic              mv_dir,
  output logic [REQ_AW-1:0] mv_idx,
  input  logic              td_done,
  input  logic              fd_done,
  output logic              db_valid,
  input  logic              db_ready,
  output logic [1:0]        db_size,
  output logic [23:0]       db_addr,
  output logic [31:0]       db_data,
  input  logic [RSP_AW-1:0] rsp_rd_addr,
  output logic [15:0]       rsp_rd_data,
  input  logic              rsp_head_we,
  input  logic [RSP_AW-1:0] rsp_head_wdata,
  output logic [RSP_AW-1:0] rsp_head,
  output logic [RSP_AW-1:0] rsp_tail,
  input  logic              irq_force,
  output logic              irq
);
  localparam int RSP_W = 2 * STAT_W;

  st_e                  state;
  logic [REQ_AW-1:0]    head_q;
  logic [DESC_W-1:0]    desc;
  logic [STAT_W-1:0]    stat_q;
  logic [1:0][CNT_W-1:0] cnt;
  logic                 full, post, fire;
  kind_e                kind;
  logic                 dir, db_en, fence_ok;
  logic [1:0]           dbw;
  logic [RSP_W-1:0]     entry;
  logic                 unused_bits;

  dmaq_ram #(.AW(REQ_AW), .DW(DESC_W)) u_req_ram (
    .clk(clk), .we(req_wr_en), .waddr(req_wr_addr), .wdata(req_wr_data),
    .raddr(head_q), .rdata(desc)
  );

  assign kind     = kind_e'(desc[F_KIND +: 2]);
  assign dir      = desc[F_KIND + 1];
  assign dbw      = desc[F_DBW +: 2];
  assign db_en    = desc[F_DBEN];
  assign fence_ok = !(desc[F_TD_FENCE] && (cnt[0] != '0)) &&
                    !(desc[F_FD_FENCE] && (cnt[1] != '0));
  assign unused_bits = desc[F_SPARE];

  assign mv_valid = (state == S_ISSUE);
  assign mv_dir   = dir;
  assign mv_idx   = head_q;
  assign db_valid = (state == S_DBELL);
  assign db_size  = dbw;
  assign db_addr  = desc[F_DBADDR +: DB_AW];
  assign db_data  = desc[F_DBDATA +: DB_DW];
  assign req_head = head_q;
  assign fire     = mv_valid && mv_ready;
  assign post     = (state == S_POST) && !full;
  assign entry    = {{(STAT_W-REQ_AW){1'b0}}, head_q, stat_q};

  dmaq_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .start_fire(fire), .start_dir(dir),
    .td_done(td_done), .fd_done(fd_done), .cnt(cnt)
  );

  dmaq_resp #(.AW(RSP_AW)) u_resp (
    .clk(clk), .rst(rst), .post(post), .head_we(rsp_head_we),
    .head_wdata(rsp_head_wdata), .irq_force(irq_force),
    .tail(rsp_tail), .head(rsp_head), .full(full), .irq(irq)
  );

  dmaq_ram #(.AW(RSP_AW), .DW(RSP_W)) u_rsp_ram (
    .clk(clk), .we(post), .waddr(rsp_tail), .wdata(entry),
    .raddr(rsp_rd_addr), .rdata(rsp_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      head_q <= '0;
      stat_q <= ST_OK;
    end else begin
      case (state)
        S_IDLE:   if (req_tail != head_q) state <= S_DECODE;
        S_DECODE: begin
          stat_q <= ST_OK;
          case (kind)
            K_NONE:  state <= S_DBCHK;
            K_BAD:   begin stat_q <= ST_BAD_KND; state <= S_POST; end
            default: state <= S_FENCE;
          endcase
        end
        S_FENCE:  if (fence_ok) state <= S_ISSUE;
        S_ISSUE:  if (mv_ready) state <= db_en ? S_DRAIN : S_POST;
        S_DRAIN:  if (cnt[dir] == '0) state <= S_DBCHK;
        S_DBCHK: begin
          if (!db_en) state <= S_POST;
          else if (dbw == 2'd3) begin stat_q <= ST_BAD_DB; state <= S_POST; end
          else state <= S_DBELL;
        end
        S_DBELL:  if (db_ready) state <= S_POST;
        S_POST: if (!full) begin
          head_q <= head_q + 1'b1;
          state  <= S_IDLE;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaq_engine_chk.sv
module dmaq_engine_chk #(
  parameter int REQ_AW = 3,
  parameter int RSP_AW = 2,
  parameter int CNT_W  = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  mv_valid,
  input logic                  mv_ready,
  input logic                  mv_dir,
  input logic [REQ_AW-1:0]     mv_idx,
  input logic                  db_valid,
  input logic                  db_ready,
  input logic [1:0]            db_size,
  input logic [RSP_AW-1:0]     rsp_tail,
  input logic [RSP_AW-1:0]     rsp_head,
  input logic                  irq,
  input logic                  irq_force,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic [63:0]           desc
);
  logic [RSP_AW-1:0] tail_inc;
  assign tail_inc = rsp_tail + 1'b1;

  AST_MV_HOLD: assert property (@(posedge clk) disable iff (rst)
    mv_valid && !mv_ready |=> mv_valid && $stable(mv_idx) && $stable(mv_dir)); // R13
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (rst)
    db_valid && !db_ready |=> db_valid && $stable(db_size)); // R13
  AST_DB_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
    db_valid |-> db_size != 2'd3); // R4
  AST_NO_MOVE_ON_BAD_KIND: assert property (@(posedge clk) disable iff (rst)
    mv_valid |-> (desc[1:0] == 2'd1 || desc[1:0] == 2'd2)); // R2
  AST_TD_FENCE: assert property (@(posedge clk) disable iff (rst)
    mv_valid && desc[30] |-> cnt[0] == '0); // R5
  AST_FD_FENCE: assert property (@(posedge clk) disable iff (rst)
    mv_valid && desc[29] |-> cnt[1] == '0); // R6
  AST_DB_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    db_valid && desc[1:0] != 2'd0 |-> cnt[desc[1]] == '0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tail_inc == rsp_head |=> rsp_tail == $past(rsp_tail)); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_force) || rsp_tail != $past(rsp_tail)); // R11
  AST_IRQ_FORCE: assert property (@(posedge clk) disable iff (rst)
    irq_force |=> irq); // R12
endmodule

bind dmaq_engine dmaq_engine_chk #(.REQ_AW(REQ_AW), .RSP_AW(RSP_AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_dir(mv_dir),
  .mv_idx(mv_idx), .db_valid(db_valid), .db_ready(db_ready), .db_size(db_size),
  .rsp_tail(rsp_tail), .rsp_head(rsp_head), .irq(irq), .irq_force(irq_force),
  .cnt(cnt), .desc(desc)
);

// File: tb/tb_dmaq_engine.sv
module tb_dmaq_engine;
  localparam int CLK_NS = 10;
  localparam int REQ_AW = 3;
  localparam int RSP_AW = 2;
  localparam int CNT_W  = 4;
  localparam int NV     = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req_wr_en = 1'b0;
  logic [REQ_AW-1:0] req_wr_addr = '0, req_tail = '0, req_head, mv_idx;
  logic [63:0] req_wr_data = '0;
  logic mv_valid, mv_ready = 1'b1, mv_dir, td_done = 1'b0, fd_done = 1'b0;
  logic db_valid, db_ready = 1'b1;
  logic [1:0] db_size;
  logic [23:0] db_addr;
  logic [31:0] db_data;
  logic [RSP_AW-1:0] rsp_rd_addr = '0, rsp_head_wdata = '0, rsp_head, rsp_tail;
  logic [15:0] rsp_rd_data;
  logic rsp_head_we = 1'b0, irq_force = 1'b0, irq;

  dmaq_engine #(.REQ_AW(REQ_AW), .RSP_AW(RSP_AW), .CNT_W(CNT_W)) dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int n_td = 0, n_fd = 0, n_db = 0, n_irq = 0, pend_td = 0, pend_fd = 0;
  logic [1:0] last_size = '0;
  logic [31:0] last_data = '0;
  logic auto_done = 1'b1;
  logic [REQ_AW-1:0] tail_sw = '0;

  // handshakes counted at the edge, where flop outputs still hold pre-edge values
  always @(posedge clk) if (!rst) begin
    if (mv_valid && mv_ready) begin
      if (mv_dir) begin n_fd++; pend_fd++; end else begin n_td++; pend_td++; end
    end
    if (db_valid && db_ready) begin n_db++; last_size = db_size; last_data = db_data; end
  end

  always @(negedge clk) begin
    td_done = 1'b0; fd_done = 1'b0;
    if (!rst && auto_done) begin
      if (pend_td > 0) begin td_done = 1'b1; pend_td--; end
      if (pend_fd > 0) begin fd_done = 1'b1; pend_fd--; end
    end
    if (!rst && irq) n_irq++;
  end

  function automatic logic [63:0] mk(input logic [1:0] k, input logic en,
                                     input logic [1:0] w, input logic fdf, input logic tdf);
    return {32'hCAFE0000, 1'b0, tdf, fdf, 24'h00ABCD, en, w, k};
  endfunction

  typedef struct packed {
    logic [63:0] desc;
    logic [7:0]  st;
    logic [1:0]  xf;   // 0 none, 1 to device, 2 from device
    logic        db;
    logic [1:0]  sz;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{mk(2'd1, 1'b0, 2'd0, 1'b0, 1'b0), 8'd0, 2'd1, 1'b0, 2'd0},
    '{mk(2'd2, 1'b1, 2'd0, 1'b0, 1'b0), 8'd0, 2'd2, 1'b1, 2'd0},
    '{mk(2'd0, 1'b1, 2'd1, 1'b0, 1'b0), 8'd0, 2'd0, 1'b1, 2'd1},
    '{mk(2'd1, 1'b1, 2'd2, 1'b0, 1'b0), 8'd0, 2'd1, 1'b1, 2'd2},
    '{mk(2'd3, 1'b1, 2'd0, 1'b0, 1'b0), 8'd1, 2'd0, 1'b0, 2'd0},
    '{mk(2'd2, 1'b1, 2'd3, 1'b0, 1'b0), 8'd2, 2'd2, 1'b0, 2'd0},
    '{mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0), 8'd0, 2'd0, 1'b0, 2'd0},
    '{mk(2'd1, 1'b0, 2'd3, 1'b0, 1'b0), 8'd0, 2'd1, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic submit(input logic [63:0] d);
    @(negedge clk);
    req_wr_en = 1'b1; req_wr_addr = tail_sw; req_wr_data = d;
    @(negedge clk);
    req_wr_en = 1'b0;
    tail_sw = tail_sw + 1'b1;
    req_tail = tail_sw;
  endtask

  task automatic wait_tail(input logic [RSP_AW-1:0] exp, input string tag);
    int k = 0;
    while (rsp_tail != exp && k < 400) begin @(negedge clk); k++; end
    chk(tag, rsp_tail, exp);
  endtask

  task automatic consume();
    @(negedge clk);
    rsp_head_we = 1'b1; rsp_head_wdata = rsp_tail;
    @(negedge clk);
    rsp_head_we = 1'b0;
  endtask

  task automatic read_rsp(input logic [RSP_AW-1:0] a, output logic [15:0] e);
    @(negedge clk);
    rsp_rd_addr = a;
    @(negedge clk);
    e = rsp_rd_data;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] e;
    logic [RSP_AW-1:0] t0;
    logic [REQ_AW-1:0] s0;
    int a, b, c, q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("reset req_head", req_head, 0);
    chk("reset rsp_tail", rsp_tail, 0);
    chk("reset rsp_head", rsp_head, 0);
    chk("reset irq", irq, 0);
    chk("reset mv_valid", mv_valid, 0);
    chk("reset db_valid", db_valid, 0);

    // vector table: R1 R2 R3 R4 R9 R11
    for (int i = 0; i < NV; i++) begin
      a = n_td; b = n_fd; c = n_db; q = n_irq;
      t0 = rsp_tail; s0 = tail_sw;
      submit(VEC[i].desc);
      wait_tail(t0 + 1'b1, "R9 response written");
      repeat (3) @(negedge clk);
      read_rsp(t0, e);
      chk($sformatf("R1/R2/R4 status vec%0d", i), e[7:0], VEC[i].st);
      chk($sformatf("R9 slot idx vec%0d", i), e[15:8], s0);
      chk($sformatf("R1 to-device moves vec%0d", i), n_td - a, VEC[i].xf == 2'd1);
      chk($sformatf("R1 from-device moves vec%0d", i), n_fd - b, VEC[i].xf == 2'd2);
      chk($sformatf("R3 doorbell count vec%0d", i), n_db - c, VEC[i].db);
      if (VEC[i].db) begin
        chk($sformatf("R3 doorbell size vec%0d", i), last_size, VEC[i].sz);
        chk($sformatf("R3 doorbell data vec%0d", i), last_data, 32'hCAFE0000);
      end
      chk($sformatf("R11 irq on empty vec%0d", i), n_irq - q, 1);
      consume();
    end

    // R13 backpressure on the mover handshake
    mv_ready = 1'b0;
    t0 = rsp_tail; s0 = tail_sw;
    submit(mk(2'd1, 1'b0, 2'd0, 1'b0, 1'b0));
    repeat (6) @(negedge clk);
    chk("R13 mv_valid held", mv_valid, 1);
    chk("R13 mv_idx held", mv_idx, s0);
    chk("R13 no response while stalled", rsp_tail, t0);
    mv_ready = 1'b1;
    wait_tail(t0 + 1'b1, "R13 completes after ready");
    consume();
    repeat (3) @(negedge clk);

    // R5 R6 R7 fences with moves left outstanding
    auto_done = 1'b0;
    t0 = rsp_tail; a = n_td; b = n_fd;
    submit(mk(2'd1, 1'b0, 2'd0, 1'b0, 1'b0));
    wait_tail(t0 + 1'b1, "R5 unfenced to-device posts");
    submit(mk(2'd2, 1'b0, 2'd0, 1'b1, 1'b0));
    wait_tail(t0 + 2'd2, "R6 from-device fence ignores to-device");
    chk("R6 from-device started", n_fd - b, 1);
    consume();
    t0 = rsp_tail;
    submit(mk(2'd1, 1'b0, 2'd0, 1'b0, 1'b1));
    submit(mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0));
    repeat (10) @(negedge clk);
    chk("R5 fenced move held", n_td - a, 1);
    chk("R7 later request held behind fence", rsp_tail, t0);
    auto_done = 1'b1;
    wait_tail(t0 + 2'd2, "R7 both complete after drain");
    chk("R5 fenced move started", n_td - a, 2);
    consume();
    repeat (4) @(negedge clk);

    auto_done = 1'b0;
    t0 = rsp_tail; b = n_fd;
    submit(mk(2'd2, 1'b0, 2'd0, 1'b0, 1'b0));
    wait_tail(t0 + 1'b1, "R6 first from-device posts");
    submit(mk(2'd2, 1'b0, 2'd0, 1'b1, 1'b0));
    repeat (10) @(negedge clk);
    chk("R6 fenced from-device held", n_fd - b, 1);
    auto_done = 1'b1;
    wait_tail(t0 + 2'd2, "R6 fenced from-device completes");
    chk("R6 fenced from-device started", n_fd - b, 2);
    consume();
    repeat (4) @(negedge clk);

    // R8 doorbell waits for done
    auto_done = 1'b0;
    t0 = rsp_tail; c = n_db;
    submit(mk(2'd2, 1'b1, 2'd2, 1'b0, 1'b0));
    repeat (10) @(negedge clk);
    chk("R8 no doorbell before done", n_db - c, 0);
    chk("R9 no response before doorbell", rsp_tail, t0);
    auto_done = 1'b1;
    wait_tail(t0 + 1'b1, "R8 posts after done");
    chk("R8 doorbell after done", n_db - c, 1);
    consume();
    repeat (3) @(negedge clk);

    // R10 full ring stalls; R11 single pulse while non-empty
    t0 = rsp_tail; s0 = tail_sw; q = n_irq;
    for (int i = 0; i < 4; i++) submit(mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0));
    repeat (40) @(negedge clk);
    chk("R10 stalls at three entries", rsp_tail, t0 + 2'd3);
    chk("R10 fourth request not consumed", req_head, s0 + 3'd3);
    chk("R11 one pulse for non-empty run", n_irq - q, 1);
    read_rsp(t0, e);
    chk("R10 oldest entry not overwritten", e[15:8], s0);
    consume();
    wait_tail(t0, "R10 fourth posts after space");
    consume();
    repeat (3) @(negedge clk);

    // R11 post coinciding with a host head write
    t0 = rsp_tail;
    submit(mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0));
    wait_tail(t0 + 1'b1, "R11 first entry");
    repeat (3) @(negedge clk);
    q = n_irq;
    submit(mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0));
    wait_tail(t0 + 2'd2, "R11 second entry");
    repeat (3) @(negedge clk);
    chk("R11 no pulse into non-empty", n_irq - q, 0);
    q = n_irq;
    submit(mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    rsp_head_we = 1'b1; rsp_head_wdata = rsp_tail;
    @(negedge clk);
    rsp_head_we = 1'b0;
    wait_tail(t0 + 2'd3, "R11 third entry");
    repeat (2) @(negedge clk);
    chk("R11 pulse with same-cycle head write", n_irq - q, 1);
    consume();
    repeat (3) @(negedge clk);

    // R12 forced interrupt
    q = n_irq;
    irq_force = 1'b1;
    @(negedge clk);
    irq_force = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 forced pulse", n_irq - q, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule